// File: doc/BRIEF.md
# Endpoint buffer status and control register

This block is the 16-bit status and control word for the DMA-side data port of a USB device controller. It keeps one small state record for each pipe: whether the pipe's buffer currently holds valid data, the byte count of the last received packet, and a received-packet counter. It shows the record of the pipe that the port has selected. The meaning of the valid flag depends on pipe direction. On a receive (OUT) pipe it means the buffer holds data that the host may read. On a transmit (IN) pipe it means the data written into the buffer is complete.

The packet engine reports events, each tagged with a pipe index: packet received (with full and short qualifiers and a length), buffer drained, and buffer write complete. The host writes the control word to request a short-packet commit on an IN pipe or a buffer flush. The block accepts a flush only when it makes sense for the pipe's direction. Accepted commands leave the block as one-cycle request pulses. A port-ready output tells the DMA side when the data port may be touched. It drops while a pipe selection settles.

Top module: `ep_buf_status`

## Requirements
- R1: A hardware reset (rst_n low at a clock edge) or a software reset (sw_rst high at a clock edge) clears all pipe records. After either reset, rd_data is 0x0000, and port_rdy, clr_req and short_req are 0.
- R2: The readback layout is fixed. Bit 15 is the valid flag of the selected pipe. Bit 13 is port_rdy. Bits 9:0 are the length. Bits 14 and 12:10 always read 0.
- R3: On an OUT pipe (dir_in bit 0), a received packet sets the valid flag when rx_full is 1. It also sets the flag when rx_short is 1 while the pipe's cont bit is 1.
- R4: On an OUT pipe with its cont bit 0, any received packet sets the valid flag.
- R5: On an OUT pipe with its trcnt_en bit 1, the valid flag is set by the packet that brings the pipe's received-packet count to trcnt_val. The count then restarts. Packets before that one set nothing unless R3 or R4 applies.
- R6: On an OUT pipe, a drain event clears the valid flag. A host write of 1 to bit 15 does not change the flag.
- R7: On an IN pipe (dir_in bit 1), a write-complete event sets the valid flag and a drain event clears it. A host write with bit 15 = 1 gives one short_req pulse in the next cycle and sets the flag. A write with bit 15 = 0 gives no pulse.
- R8: A host write with bit 14 = 1 is accepted only when the selected OUT pipe's flag is 1, or the selected IN pipe's flag is 0. When it is accepted, clr_req pulses for one cycle after the write, and the pipe's flag, length and packet count go to 0. Otherwise, and whenever bit 14 = 0, nothing happens. An accepted clear takes priority over a set event to the same pipe in the same cycle.
- R9: When the selection is stable, port_rdy is 1 two cycles after an OUT pipe's flag becomes 1, or while an IN pipe's flag is 0. It is 0 otherwise.
- R10: Every received packet on an OUT pipe loads its rx_len into the pipe's length field. Host writes to bits 12:0 never change the length.
- R11: A change of pipe_sel makes port_rdy 0 in the next cycle. The readback shows the new pipe's stored flag and length at once. Events for pipes that are not selected update their own records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset, active high |
| pipe_sel | input | 3 | Pipe currently selected on the data port |
| dir_in | input | 8 | Per pipe: 1 = IN (transmit), 0 = OUT (receive) |
| cont | input | 8 | Per pipe: continuous transfer mode |
| trcnt_en | input | 8 | Per pipe: transfer-count completion enabled |
| trcnt_val | input | 16 | Packet count that completes a counted transfer |
| reg_wr | input | 1 | Host write strobe for the control word |
| wr_data | input | 16 | Host write data |
| rd_data | output | 16 | Readback of the selected pipe's status |
| ev_pipe | input | 3 | Pipe index of the packet-engine event |
| rx_stb | input | 1 | A packet was received |
| rx_full | input | 1 | The received packet filled the buffer |
| rx_short | input | 1 | The received packet was short |
| rx_len | input | 10 | Byte count of the received packet |
| drain_stb | input | 1 | Buffer emptied (read out or transmitted) |
| wdone_stb | input | 1 | Buffer writing complete on an IN pipe |
| short_req | output | 1 | One-cycle short-packet commit request |
| clr_req | output | 1 | One-cycle buffer flush request |
| port_rdy | output | 1 | Data port may be accessed |

## Verification
A table drives single packets into one OUT pipe over all combinations of the full and short qualifiers, with continuous mode on and off. This separates the full rule, the short-in-continuous rule and the any-packet rule of non-continuous mode. It also shows that a plain packet in continuous mode leaves the flag low. A counted transfer checks that the flag rises on the exact packet that reaches the preset and on no earlier one. Directed cases try a flush in both allowed and forbidden flag states on both directions, the short-packet write with bit 15 at 1 and at 0, pipe switching with an event aimed at an unselected pipe, and both resets.

// File: rtl/ep_stat_pkg.sv
// Shared field positions and widths of the endpoint buffer status word.
// Assumes a 16-bit control word; bit positions are decoded by the host driver.
package ep_stat_pkg;
    localparam int WORD_W    = 16;
    localparam int VALID_BIT = 15;
    localparam int CLR_BIT   = 14;
    localparam int RDY_BIT   = 13;
    localparam int LEN_W     = 10;
    localparam int CNT_W     = 16;
endpackage

// File: rtl/ep_pipe_slot.sv
// One pipe's record: valid flag, last received length and received-packet count.
// Assumes event strobes are already qualified with this pipe's index.
// Priority per cycle: accepted clear, then set, then drain.
module ep_pipe_slot #(
    parameter int LEN_W = 10,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             dir_in,
    input  logic             cont,
    input  logic             trcnt_en,
    input  logic [CNT_W-1:0] trcnt_val,
    input  logic             rx_hit,
    input  logic             rx_full,
    input  logic             rx_short,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             drain_hit,
    input  logic             wdone_hit,
    input  logic             commit_hit,
    input  logic             clear_hit,
    output logic             valid,
    output logic [LEN_W-1:0] len
);
    logic [CNT_W-1:0] pkt_cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             cnt_reached;
    logic             out_rx;
    logic             out_set;
    logic             in_set;
    logic             set_flag;

    // Decide which events raise the flag for the current direction.
    always_comb begin
        cnt_next    = pkt_cnt + 1'b1;
        cnt_reached = trcnt_en && (cnt_next == trcnt_val);
        out_rx      = rx_hit && !dir_in;
        out_set     = out_rx && (rx_full || (rx_short && cont) || !cont || cnt_reached);
        in_set      = dir_in && (wdone_hit || commit_hit);
        set_flag    = out_set || in_set;
    end

    // Valid flag update with clear over set over drain.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)  valid <= 1'b0;
        else if (clear_hit)    valid <= 1'b0;
        else if (set_flag)     valid <= 1'b1;
        else if (drain_hit)    valid <= 1'b0;
    end

    // Length capture from received packets on an OUT pipe.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)  len <= '0;
        else if (clear_hit)    len <= '0;
        else if (out_rx)       len <= rx_len;
    end

    // Received-packet counter for counted transfers, restarting at the preset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst)           pkt_cnt <= '0;
        else if (clear_hit)             pkt_cnt <= '0;
        else if (out_rx && trcnt_en)    pkt_cnt <= cnt_reached ? '0 : cnt_next;
    end

    // R6
    out_rise_needs_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(valid) && !dir_in && $past(!dir_in)) |-> $past(rx_hit));

    // R8
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_hit |=> (!valid && len == '0));
endmodule

// File: rtl/ep_cmd_decode.sv
// Decodes host writes into short-packet commits and gated buffer flushes.
// Assumes the selected pipe's direction and flag are given combinationally.
module ep_cmd_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_rst,
    input  logic reg_wr,
    input  logic cmd_valid,
    input  logic cmd_clr,
    input  logic sel_dir_in,
    input  logic sel_valid,
    output logic commit_ok,
    output logic clear_ok,
    output logic short_req,
    output logic clr_req
);
    logic clr_allowed;

    // Gate commands on direction and the selected pipe's flag.
    always_comb begin
        clr_allowed = sel_dir_in ? !sel_valid : sel_valid;
        commit_ok   = reg_wr && cmd_valid && sel_dir_in;
        clear_ok    = reg_wr && cmd_clr && clr_allowed;
    end

    // Register the accepted commands as request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            short_req <= 1'b0;
            clr_req   <= 1'b0;
        end else begin
            short_req <= commit_ok;
            clr_req   <= clear_ok;
        end
    end

    // R8
    clr_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |-> $past(reg_wr && cmd_clr));

    // R7
    short_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        short_req |-> $past(reg_wr && cmd_valid && sel_dir_in));
endmodule

// File: rtl/ep_port_ready.sv
// Port-ready flag: registered access permission, forced low for a cycle after
// any change of the selected pipe. Assumes access_ok describes the selected pipe.
module ep_port_ready #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic [SEL_W-1:0] pipe_sel,
    input  logic             access_ok,
    output logic             port_rdy
);
    logic [SEL_W-1:0] sel_q;

    // Track the previous selection and register permission when it is settled.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            sel_q    <= '0;
            port_rdy <= 1'b0;
        end else begin
            sel_q    <= pipe_sel;
            port_rdy <= (pipe_sel == sel_q) && access_ok;
        end
    end

    // R11
    sel_change_drop_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (pipe_sel != $past(pipe_sel)) |=> !port_rdy);
endmodule

// File: rtl/ep_buf_status.sv
// Top: per-pipe records, command decode, port-ready and readback assembly.
// Assumes events arrive as single-cycle strobes tagged with ev_pipe, and that
// host writes act on the pipe given by pipe_sel.
module ep_buf_status #(
    parameter int NUM_PIPES = 8,
    parameter int SEL_W     = $clog2(NUM_PIPES),
    parameter int LEN_W     = ep_stat_pkg::LEN_W,
    parameter int CNT_W     = ep_stat_pkg::CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_rst,
    input  logic [SEL_W-1:0]     pipe_sel,
    input  logic [NUM_PIPES-1:0] dir_in,
    input  logic [NUM_PIPES-1:0] cont,
    input  logic [NUM_PIPES-1:0] trcnt_en,
    input  logic [CNT_W-1:0]     trcnt_val,
    input  logic                 reg_wr,
    input  logic [15:0]          wr_data,
    output logic [15:0]          rd_data,
    input  logic [SEL_W-1:0]     ev_pipe,
    input  logic                 rx_stb,
    input  logic                 rx_full,
    input  logic                 rx_short,
    input  logic [LEN_W-1:0]     rx_len,
    input  logic                 drain_stb,
    input  logic                 wdone_stb,
    output logic                 short_req,
    output logic                 clr_req,
    output logic                 port_rdy
);
    import ep_stat_pkg::*;

    localparam int RSV_W = RDY_BIT - LEN_W;

    logic [NUM_PIPES-1:0] valid_vec;
    logic [LEN_W-1:0]     len_arr [NUM_PIPES];
    logic                 sel_valid;
    logic                 sel_dir;
    logic [LEN_W-1:0]     sel_len;
    logic                 commit_ok;
    logic                 clear_ok;
    logic                 access_ok;

    // Select the record shown on the port.
    always_comb begin
        sel_valid = valid_vec[pipe_sel];
        sel_dir   = dir_in[pipe_sel];
        sel_len   = len_arr[pipe_sel];
        access_ok = sel_dir ? !sel_valid : sel_valid;
    end

    // One record per pipe, with events routed by index.
    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        logic sel_me;
        logic ev_me;
        assign sel_me = (pipe_sel == SEL_W'(p));
        assign ev_me  = (ev_pipe == SEL_W'(p));

        ep_pipe_slot #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .sw_rst     (sw_rst),
            .dir_in     (dir_in[p]),
            .cont       (cont[p]),
            .trcnt_en   (trcnt_en[p]),
            .trcnt_val  (trcnt_val),
            .rx_hit     (rx_stb && ev_me),
            .rx_full    (rx_full),
            .rx_short   (rx_short),
            .rx_len     (rx_len),
            .drain_hit  (drain_stb && ev_me),
            .wdone_hit  (wdone_stb && ev_me),
            .commit_hit (commit_ok && sel_me),
            .clear_hit  (clear_ok && sel_me),
            .valid      (valid_vec[p]),
            .len        (len_arr[p])
        );
    end

    ep_cmd_decode u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_rst     (sw_rst),
        .reg_wr     (reg_wr),
        .cmd_valid  (wr_data[VALID_BIT]),
        .cmd_clr    (wr_data[CLR_BIT]),
        .sel_dir_in (sel_dir),
        .sel_valid  (sel_valid),
        .commit_ok  (commit_ok),
        .clear_ok   (clear_ok),
        .short_req  (short_req),
        .clr_req    (clr_req)
    );

    ep_port_ready #(.SEL_W(SEL_W)) u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .pipe_sel  (pipe_sel),
        .access_ok (access_ok),
        .port_rdy  (port_rdy)
    );

    // Assemble the readback word; the clear bit and reserved bits read zero.
    always_comb begin
        rd_data = {sel_valid, 1'b0, port_rdy, {RSV_W{1'b0}}, sel_len};
    end

    // R10
    len_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (reg_wr && wr_data[15:14] == 2'b00 && wr_data[13:0] != '0 && !rx_stb)
        |=> (rd_data[LEN_W-1:0] == $past(rd_data[LEN_W-1:0])) || (pipe_sel != $past(pipe_sel)));

    // R1
    sw_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (valid_vec == '0 && !port_rdy && !clr_req && !short_req));
endmodule

// File: tb/ep_buf_status_test.sv
module ep_buf_status_test;
    logic        clk = 1'b0;
    logic        rst_n, sw_rst;
    logic [2:0]  pipe_sel, ev_pipe;
    logic [7:0]  dir_in, cont, trcnt_en;
    logic [15:0] trcnt_val, wr_data, rd_data;
    logic        reg_wr, rx_stb, rx_full, rx_short, drain_stb, wdone_stb;
    logic [9:0]  rx_len;
    logic        short_req, clr_req, port_rdy;
    int          checks = 0;
    int          errors = 0;
    logic        p_short, p_clr, q_short, q_clr;

    // cont, full, short, expected valid, length
    localparam logic [13:0] VEC [0:5] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 10'd17},
        {1'b0, 1'b0, 1'b1, 1'b1, 10'd5},
        {1'b1, 1'b1, 1'b0, 1'b1, 10'd512},
        {1'b1, 1'b0, 1'b1, 1'b1, 10'd3},
        {1'b1, 1'b0, 1'b0, 1'b0, 10'd64},
        {1'b0, 1'b1, 1'b0, 1'b1, 10'd1023}
    };

    always #2 clk = ~clk;

    ep_buf_status uut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .pipe_sel(pipe_sel),
        .dir_in(dir_in), .cont(cont), .trcnt_en(trcnt_en), .trcnt_val(trcnt_val),
        .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data), .ev_pipe(ev_pipe),
        .rx_stb(rx_stb), .rx_full(rx_full), .rx_short(rx_short), .rx_len(rx_len),
        .drain_stb(drain_stb), .wdone_stb(wdone_stb), .short_req(short_req),
        .clr_req(clr_req), .port_rdy(port_rdy)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rx(input logic [2:0] p, input logic f, input logic s, input logic [9:0] l);
        ev_pipe = p; rx_full = f; rx_short = s; rx_len = l; rx_stb = 1'b1;
        @(negedge clk); rx_stb = 1'b0; rx_full = 1'b0; rx_short = 1'b0;
    endtask

    task automatic drain(input logic [2:0] p);
        ev_pipe = p; drain_stb = 1'b1;
        @(negedge clk); drain_stb = 1'b0;
    endtask

    task automatic wdone(input logic [2:0] p);
        ev_pipe = p; wdone_stb = 1'b1;
        @(negedge clk); wdone_stb = 1'b0;
    endtask

    // p_* = pulse the cycle after the write, q_* = one cycle later
    task automatic wr(input logic [15:0] d);
        wr_data = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0; wr_data = '0;
        p_short = short_req; p_clr = clr_req;
        @(negedge clk);
        q_short = short_req; q_clr = clr_req;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sw_rst = 1'b0; pipe_sel = '0; ev_pipe = '0;
        dir_in = 8'h02; cont = '0; trcnt_en = '0; trcnt_val = '0;
        reg_wr = 1'b0; wr_data = '0; rx_stb = 1'b0; rx_full = 1'b0;
        rx_short = 1'b0; rx_len = '0; drain_stb = 1'b0; wdone_stb = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 hw reset rd_data", rd_data, 16'h0000);
        chk("R1 hw reset outputs", {13'b0, port_rdy, clr_req, short_req}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk on OUT pipe 0
        foreach (VEC[i]) begin
            cont[0] = VEC[i][13];
            rx(3'd0, VEC[i][12], VEC[i][11], VEC[i][9:0]);
            chk($sformatf("R3 R4 R10 R2 vector %0d", i),
                {rd_data[15:14], 1'b0, rd_data[12:0]}, {VEC[i][10], 5'b0, VEC[i][9:0]});
            drain(3'd0);
            chk($sformatf("R6 drain vector %0d", i), {15'b0, rd_data[15]}, 16'h0);
        end

        // Counted transfer: preset 3, plain packets in continuous mode
        cont[0] = 1'b1; trcnt_en[0] = 1'b1; trcnt_val = 16'd3;
        rx(3'd0, 1'b0, 1'b0, 10'd8);
        rx(3'd0, 1'b0, 1'b0, 10'd8);
        chk("R5 before preset", {15'b0, rd_data[15]}, 16'h0);
        rx(3'd0, 1'b0, 1'b0, 10'd9);
        chk("R5 at preset", {15'b0, rd_data[15]}, 16'h1);
        trcnt_en[0] = 1'b0;

        // Port ready on OUT with data, settled two cycles
        @(negedge clk);
        chk("R9 R2 OUT ready", {15'b0, port_rdy}, 16'h1);
        chk("R2 readback with ready", rd_data, 16'hA009);

        // Writes of length/reserved/valid bits ignored on OUT
        wr(16'h9FFF);
        chk("R6 R10 OUT write ignored", rd_data, 16'hA009);
        chk("R7 no short on OUT", {14'b0, p_short, q_short}, 16'h0);

        // Clear with bit 14 = 0 ignored, then accepted clear
        wr(16'h0000);
        chk("R8 bit14 zero ignored", {14'b0, p_clr, rd_data[15]}, 16'h1);
        wr(16'h4000);
        chk("R8 OUT clear pulse", {14'b0, p_clr, q_clr}, 16'h2);
        chk("R8 OUT clear state", {rd_data[15:14], rd_data[12:0]}, 15'h0);
        wr(16'h4000);
        chk("R8 OUT clear rejected when empty", {14'b0, p_clr, q_clr}, 16'h0);

        // Clear wins over a same-cycle set
        rx(3'd0, 1'b1, 1'b0, 10'd4);
        wr_data = 16'h4000; reg_wr = 1'b1; ev_pipe = 3'd0; rx_full = 1'b1;
        rx_stb = 1'b1; rx_len = 10'd6;
        @(negedge clk);
        reg_wr = 1'b0; rx_stb = 1'b0; rx_full = 1'b0; wr_data = '0;
        chk("R8 clear beats set", {6'b0, rd_data[15], rd_data[9:0]}, 17'h0);

        // Event to unselected pipe 0 while pipe 1 (IN) is selected
        pipe_sel = 3'd1;
        @(negedge clk);
        chk("R11 ready drops on switch", {15'b0, port_rdy}, 16'h0);
        chk("R11 new pipe shown", {rd_data[15], rd_data[9:0]}, 11'h0);
        rx(3'd0, 1'b1, 1'b0, 10'd77);
        chk("R9 IN empty ready", {15'b0, port_rdy}, 16'h1);

        // IN: write 0 to bit 15 no effect, write 1 commits
        wr(16'h0000);
        chk("R7 zero write no short", {13'b0, p_short, q_short, rd_data[15]}, 16'h0);
        wr(16'h8000);
        chk("R7 short pulse", {14'b0, p_short, q_short}, 16'h2);
        chk("R7 commit sets valid", {15'b0, rd_data[15]}, 16'h1);
        @(negedge clk);
        chk("R9 IN full not ready", {15'b0, port_rdy}, 16'h0);
        wr(16'h4000);
        chk("R8 IN clear rejected when valid", {14'b0, p_clr, q_clr}, 16'h0);
        drain(3'd1);
        chk("R7 IN drain", {15'b0, rd_data[15]}, 16'h0);
        wdone(3'd1);
        chk("R7 IN write done", {15'b0, rd_data[15]}, 16'h1);
        drain(3'd1);
        wr(16'h4000);
        chk("R8 IN clear accepted when empty", {14'b0, p_clr, q_clr}, 16'h2);

        // Back to pipe 0: stored record from the unselected event
        pipe_sel = 3'd0;
        #0;
        chk("R11 stored record", {rd_data[15], 5'b0, rd_data[9:0]}, 16'h804D);
        @(negedge clk);
        chk("R11 ready low after return", {15'b0, port_rdy}, 16'h0);
        @(negedge clk); @(negedge clk);
        chk("R9 ready restored", {15'b0, port_rdy}, 16'h1);

        // Software reset
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        chk("R1 sw reset rd_data", rd_data, 16'h0000);
        chk("R1 sw reset outputs", {13'b0, port_rdy, clr_req, short_req}, 16'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule